// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Serial Output Port

This block is the digital half of a six-channel, 12-bit converter that samples all of its channels at once. A rising edge on the start request, seen on a rising edge of the serial clock, captures one word per channel from a parallel input. In a real device that input would come from the conversion core; here it supplies ideal codes. The block then runs a frame on the serial clock. Each enabled channel takes a 16-clock slot: two clocks with the output released, twelve data bits sent most significant bit first, then two padding bits driven low.

The words sent in a frame are not the ones just captured. Each channel has a holding latch, and the frame sends the latch contents, which are the results of that channel's previous conversion. When a channel's slot ends, its latch takes the value captured at this start. A channel that a short frame leaves out keeps its old result until a later frame includes it again. A 3-bit select value sets how many channels a frame covers. A mode flag chooses between straight-binary and two's-complement words. Both are captured at the start edge.

Top module: `simsamp_serial_port`

## Requirements
- R1: A frame that the start edge (edge E0) opens with n enabled channels lasts exactly 16·n further rising edges, E1 to E16n. From edge E16n+1 on, `ser_oe` is low until a new frame starts.
- R2: A channel select value s of 0 to 4 enables channels 0 to s, so the frame has s+1 channels. The values 5, 6 and 7 all enable six channels.
- R3: A rising start request seen while a frame is in progress is ignored. The frame keeps its length and is not restarted.
- R4: After edge Ek of a frame (k = 1 to 16n), the output shows slot position p = (k−1) mod 16 of channel (k−1) div 16. Channels go in ascending order from 0. At p = 0 and p = 1, `ser_oe` is low. At p = 2 to 13, `ser_oe` is high and `ser_out` carries word bit 13−p, so bit 11 is sent first.
- R5: At slot positions 14 and 15, `ser_oe` is high and `ser_out` is 0.
- R6: `ser_oe` is low while reset is asserted, after reset, whenever no frame is running, and just after the start edge itself.
- R7: The word sent for channel c equals the value captured for c at the last start whose frame enabled c. Reset clears every held word to zero.
- R8: In two's-complement mode (`bipolar_mode` = 1 at the start edge), the captured word is the input code with bit 11 inverted. In straight-binary mode it is the input code unchanged.
- R9: Changes to `chan_sel`, `bipolar_mode` or `core_words` after the start edge affect neither the running frame nor the captured words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock. All state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_req | input | 1 | Conversion request. A low-to-high change, sampled on sclk, opens a frame |
| chan_sel | input | 3 | Channel-count select, captured at the start edge |
| bipolar_mode | input | 1 | 1: two's-complement words; 0: straight binary. Captured at the start edge |
| core_words | input | 72 | Parallel sample codes. Channel c occupies bits [12c+11:12c] |
| ser_out | output | 1 | Serial data. Driven 0 when not enabled |
| ser_oe | output | 1 | High when ser_out is driven; low means high impedance |

## Verification
The bench sends frames with every select value, in an order where short frames follow long ones and long frames follow short ones. This exposes a design that refreshes every latch at each start instead of only the channels it converts: such a design would send the newest values for channels the previous frame skipped. In the middle of each frame the bench raises the start request again and inverts the select, mode and sample inputs. A design that restarts or re-captures would either lengthen the frame or corrupt the next frame's words. An off-by-one slot layout shows up as the output enabled during the two release clocks, or as data bits shifted by one position. A reset in the middle of a frame must silence the output at once and leave all-zero words for the next frame.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    SEG_LEAD = 2'd0,
    SEG_DATA = 2'd1,
    SEG_PAD  = 2'd2
  } seg_e;
endpackage

// File: rtl/ssp_seq.sv
module ssp_seq #(
  parameter int NUM_CH = 6,
  parameter int SEL_W  = 3,
  parameter int SLOT   = 16,
  parameter int CH_W   = 3,
  parameter int POS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [SEL_W-1:0] chan_sel,
  output logic             busy,
  output logic             start_pulse,
  output logic             slot_end,
  output logic [CH_W-1:0]  cur_ch,
  output logic [POS_W-1:0] cur_pos,
  output logic [CH_W-1:0]  last_ch
);
  logic             req_q;
  logic             busy_d;
  logic [CH_W-1:0]  ch_d, last_d;
  logic [POS_W-1:0] pos_d;
  logic [CH_W-1:0]  sel_last;

  always_comb begin
    if (int'(chan_sel) >= NUM_CH - 1) sel_last = CH_W'(NUM_CH - 1);
    else                              sel_last = CH_W'(chan_sel);
  end

  assign start_pulse = start_req && !req_q && !busy;
  assign slot_end    = busy && (cur_pos == POS_W'(SLOT - 1));

  always_comb begin
    busy_d = busy;
    ch_d   = cur_ch;
    pos_d  = cur_pos;
    last_d = last_ch;
    if (start_pulse) begin
      busy_d = 1'b1;
      ch_d   = '0;
      pos_d  = '0;
      last_d = sel_last;
    end else if (busy) begin
      if (slot_end) begin
        pos_d = '0;
        if (cur_ch == last_ch) busy_d = 1'b0;
        else                   ch_d   = cur_ch + 1'b1;
      end else begin
        pos_d = cur_pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      busy    <= 1'b0;
      cur_ch  <= '0;
      cur_pos <= '0;
      last_ch <= '0;
    end else begin
      req_q   <= start_req;
      busy    <= busy_d;
      cur_ch  <= ch_d;
      cur_pos <= pos_d;
      last_ch <= last_d;
    end
  end
endmodule

// File: rtl/ssp_bank.sv
module ssp_bank #(
  parameter int NUM_CH = 6,
  parameter int WORD_W = 12,
  parameter int CH_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic                     bipolar,
  input  logic [NUM_CH*WORD_W-1:0] words_in,
  input  logic                     commit,
  input  logic [CH_W-1:0]          cur_ch,
  output logic [WORD_W-1:0]        rd_word
);
  logic [WORD_W-1:0] snap_q [NUM_CH];
  logic [WORD_W-1:0] held_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WORD_W-1:0] raw, snap_d, held_d;
    logic              hit;
    assign raw = words_in[c*WORD_W +: WORD_W];
    assign hit = commit && (cur_ch == CH_W'(c));

    always_comb begin
      snap_d = snap_q[c];
      if (capture) snap_d = {raw[WORD_W-1] ^ bipolar, raw[WORD_W-2:0]};
      held_d = held_q[c];
      if (hit) held_d = snap_q[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_q[c] <= '0;
        held_q[c] <= '0;
      end else begin
        snap_q[c] <= snap_d;
        held_q[c] <= held_d;
      end
    end
  end

  always_comb begin
    if (int'(cur_ch) < NUM_CH) rd_word = held_q[cur_ch];
    else                       rd_word = '0;
  end
endmodule

// File: rtl/ssp_txd.sv
module ssp_txd
  import ssp_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int LEAD_Z = 2,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [POS_W-1:0]  cur_pos,
  input  logic [WORD_W-1:0] rd_word,
  output logic              ser_out,
  output logic              ser_oe
);
  seg_e              seg;
  logic [WORD_W-1:0] shifted;
  logic              out_d, oe_d;

  always_comb begin
    if (int'(cur_pos) < LEAD_Z)               seg = SEG_LEAD;
    else if (int'(cur_pos) < LEAD_Z + WORD_W) seg = SEG_DATA;
    else                                      seg = SEG_PAD;
  end

  assign shifted = rd_word << (cur_pos - POS_W'(LEAD_Z));

  always_comb begin
    out_d = 1'b0;
    oe_d  = 1'b0;
    if (busy) begin
      case (seg)
        SEG_DATA: begin oe_d = 1'b1; out_d = shifted[WORD_W-1]; end
        SEG_PAD:  begin oe_d = 1'b1; out_d = 1'b0; end
        default:  begin oe_d = 1'b0; out_d = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_out <= 1'b0;
      ser_oe  <= 1'b0;
    end else begin
      ser_out <= out_d;
      ser_oe  <= oe_d;
    end
  end
endmodule

// File: rtl/simsamp_serial_port.sv
module simsamp_serial_port #(
  parameter int NUM_CH = 6,
  parameter int WORD_W = 12,
  parameter int SEL_W  = 3,
  parameter int LEAD_Z = 2,
  parameter int PAD_N  = 2
) (
  input  logic                     sclk,
  input  logic                     rst_n,
  input  logic                     start_req,
  input  logic [SEL_W-1:0]         chan_sel,
  input  logic                     bipolar_mode,
  input  logic [NUM_CH*WORD_W-1:0] core_words,
  output logic                     ser_out,
  output logic                     ser_oe
);
  localparam int SLOT  = LEAD_Z + WORD_W + PAD_N;
  localparam int POS_W = $clog2(SLOT);
  localparam int CH_W  = $clog2(NUM_CH + 1);

  logic [1:0]        rst_sync;
  logic              rst_ok;
  logic              busy, start_pulse, slot_end;
  logic [CH_W-1:0]   cur_ch, last_ch;
  logic [POS_W-1:0]  cur_pos;
  logic [WORD_W-1:0] rd_word;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  ssp_seq #(
    .NUM_CH(NUM_CH), .SEL_W(SEL_W), .SLOT(SLOT), .CH_W(CH_W), .POS_W(POS_W)
  ) u_seq (
    .clk(sclk), .rst_n(rst_ok), .start_req(start_req), .chan_sel(chan_sel),
    .busy(busy), .start_pulse(start_pulse), .slot_end(slot_end),
    .cur_ch(cur_ch), .cur_pos(cur_pos), .last_ch(last_ch)
  );

  ssp_bank #(
    .NUM_CH(NUM_CH), .WORD_W(WORD_W), .CH_W(CH_W)
  ) u_bank (
    .clk(sclk), .rst_n(rst_ok), .capture(start_pulse), .bipolar(bipolar_mode),
    .words_in(core_words), .commit(slot_end), .cur_ch(cur_ch), .rd_word(rd_word)
  );

  ssp_txd #(
    .WORD_W(WORD_W), .LEAD_Z(LEAD_Z), .POS_W(POS_W)
  ) u_txd (
    .clk(sclk), .rst_n(rst_ok), .busy(busy), .cur_pos(cur_pos),
    .rd_word(rd_word), .ser_out(ser_out), .ser_oe(ser_oe)
  );
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
  parameter int NUM_CH = 6,
  parameter int WORD_W = 12,
  parameter int SEL_W  = 3,
  parameter int LEAD_Z = 2,
  parameter int SLOT   = 16,
  parameter int CH_W   = 3,
  parameter int POS_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [CH_W-1:0]  cur_ch,
  input logic [POS_W-1:0] cur_pos,
  input logic [CH_W-1:0]  last_ch,
  input logic [SEL_W-1:0] chan_sel,
  input logic             ser_out,
  input logic             ser_oe
);
  logic at_end;
  assign at_end = busy && (cur_pos == POS_W'(SLOT - 1)) && (cur_ch == last_ch);

  // R1
  frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> !busy);

  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_end) |=> busy);

  // R2
  count_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (int'(last_ch) ==
      ((int'($past(chan_sel)) >= NUM_CH - 1) ? NUM_CH - 1 : int'($past(chan_sel)))));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !ser_oe);

  // R4
  lead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(cur_pos) < LEAD_Z) |=> !ser_oe);

  // R5
  pad_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(cur_pos) >= LEAD_Z + WORD_W) |=> (ser_oe && !ser_out));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(last_ch));
endmodule

bind simsamp_serial_port ssp_chk #(
  .NUM_CH(NUM_CH), .WORD_W(WORD_W), .SEL_W(SEL_W), .LEAD_Z(LEAD_Z),
  .SLOT(SLOT), .CH_W(CH_W), .POS_W(POS_W)
) u_chk (
  .clk(sclk), .rst_n(rst_ok), .busy(busy), .cur_ch(cur_ch), .cur_pos(cur_pos),
  .last_ch(last_ch), .chan_sel(chan_sel), .ser_out(ser_out), .ser_oe(ser_oe)
);

// File: tb/simsamp_serial_port_tb.sv
`timescale 1ns/1ps
module simsamp_serial_port_tb;
  localparam int NCH = 6;
  localparam int WW  = 12;
  localparam int NV  = 10;
  // {select[15:13], bipolar[12], seed[11:0]}
  localparam logic [15:0] VEC [NV] = '{
    {3'd5, 1'b0, 12'h123}, {3'd3, 1'b1, 12'h4A0}, {3'd0, 1'b0, 12'hFFF},
    {3'd1, 1'b1, 12'h800}, {3'd7, 1'b0, 12'h055}, {3'd2, 1'b0, 12'h9C3},
    {3'd6, 1'b1, 12'h3E1}, {3'd4, 1'b0, 12'h700}, {3'd0, 1'b1, 12'h001},
    {3'd5, 1'b1, 12'hABC}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_req = 1'b0;
  logic [2:0]      chan_sel = 3'd0;
  logic            bipolar_mode = 1'b0;
  logic [NCH*WW-1:0] core_words = '0;
  logic            ser_out, ser_oe;

  int checks = 0;
  int fails  = 0;
  logic [WW-1:0] model [NCH];

  always #2.5 clk = ~clk;

  simsamp_serial_port u_dut (
    .sclk(clk), .rst_n(rst_n), .start_req(start_req), .chan_sel(chan_sel),
    .bipolar_mode(bipolar_mode), .core_words(core_words),
    .ser_out(ser_out), .ser_oe(ser_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [2:0] s, input logic b, input logic [11:0] seed);
    int n;
    logic [WW-1:0] nw [NCH];
    logic [WW-1:0] got;
    bit oe_ok;
    n = (s >= 3'd5) ? NCH : int'(s) + 1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      nw[c] = seed + WW'(c * 12'h111);
      core_words[c*WW +: WW] = nw[c];
    end
    chan_sel = s; bipolar_mode = b; start_req = 1'b1;
    @(negedge clk);
    chk(!ser_oe, "R6 start edge", int'(ser_oe), 0);
    start_req = 1'b0;
    got = '0; oe_ok = 1'b1;
    for (int k = 1; k <= 16 * n; k++) begin
      int p, c;
      @(negedge clk);
      p = (k - 1) % 16;
      c = (k - 1) / 16;
      if (k == 4) begin
        start_req = 1'b1; chan_sel = ~s; bipolar_mode = ~b; core_words = ~core_words;
      end
      if (k == 5) start_req = 1'b0;
      if (p < 2) chk(!ser_oe, "R4 lead gap", int'(ser_oe), 0);
      else if (p < 14) begin
        if (!ser_oe) oe_ok = 1'b0;
        got[13-p] = ser_out;
      end else chk(ser_oe && !ser_out, "R5 pad", int'({ser_oe, ser_out}), 2);
      if (p == 13) chk(oe_ok, "R4 data enabled", int'(oe_ok), 1);
      if (p == 15) begin
        chk(got == model[c], $sformatf("R7 R8 R9 word ch%0d", c), int'(got), int'(model[c]));
        oe_ok = 1'b1;
      end
    end
    for (int c = 0; c < n; c++) model[c] = b ? (nw[c] ^ 12'h800) : nw[c];
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!ser_oe, "R1 R2 R3 idle after frame", int'(ser_oe), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    chk(!ser_oe, "R6 in reset", int'(ser_oe), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!ser_oe, "R6 after reset", int'(ser_oe), 0);
    end

    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][15:13], VEC[v][12], VEC[v][11:0]);

    // reset in the middle of a frame clears held words
    @(negedge clk);
    chan_sel = 3'd5; start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1 chk(!ser_oe, "R6 async reset mid-frame", int'(ser_oe), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < NCH; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    chk(!ser_oe, "R6 idle after mid-frame reset", int'(ser_oe), 0);
    run_frame(3'd6, 1'b0, 12'h5A5);
    run_frame(3'd1, 1'b1, 12'h0F0);
    run_frame(3'd5, 1'b0, 12'hC3C);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule